// File: doc/BRIEF.md
# Timed Serial DAC Link Controller

This block sits on the host side of a serial link to a 14-bit voltage-output converter. The system hands it a code through a request/acknowledge handshake. The controller turns that code into a 16-bit frame and shifts it out while meeting every edge timing minimum of the link. Each frame carries the 14 code bits, most significant first, followed by two zero sub-bits. The controller drives an active-low select, a divided serial clock and serial data. When four-wire operation is chosen for a frame, it also drives a delayed active-low load strobe.

Every interval is a whole number of system clock cycles, derived by rounding up a nanosecond figure against the `CLK_PERIOD_NS` parameter. These intervals are the power-up wait, the clock high and low phases, select setup and hold, data setup, strobe delay and width, and the gap between frames. A per-frame option treats the incoming value as a two's-complement bipolar number and converts it to offset binary by flipping its top bit.

Top module: `dac_link_ctrl`

## Requirements
- R1: During reset `cs_n_o` is 1, `sclk_o` is 0, `stb_n_o` is 1 and `ready_o` and `ack_o` are 0. After reset is released, `ready_o` stays low for the power-up interval (4000 cycles at the defaults, 20 µs) and `cs_n_o` stays high throughout that interval.
- R2: `ready_o` is high only while the controller is idle, and it is never high while `cs_n_o` is low. In a cycle where `req_i` and `ready_o` are both high, the code is captured. In the next cycle `ack_o` is high for exactly one cycle and `ready_o` is low.
- R3: Each frame has exactly 16 rising edges of `sclk_o` while `cs_n_o` is low. The bits sampled at those edges are the 14-bit word, most significant bit first, followed by two 0 bits.
- R4: Every high phase and every low phase of `sclk_o` inside a frame lasts exactly `T_HALF` cycles (10 at the defaults, so 50 ns each, 10 MHz, 50% duty).
- R5: `cs_n_o` is low for at least `T_CSS` cycles (9) before the first rising edge of `sclk_o`. `sdo_o` holds its value for at least 8 cycles before every rising edge, and it changes only while `sclk_o` is low.
- R6: `cs_n_o` rises at least `T_CSH` cycles (9) after the last rising edge of `sclk_o`.
- R7: In a frame requested with `four_wire_i` = 1, `stb_n_o` goes low once, at least 10 cycles after `cs_n_o` rises, and stays low for at least 10 cycles. `stb_n_o` is never low while `cs_n_o` is low.
- R8: In a frame requested with `four_wire_i` = 0, `stb_n_o` stays high.
- R9: With `bipolar_i` = 0 the code is sent unchanged. With `bipolar_i` = 1 the code is read as two's complement and sent with bit 13 inverted: 0x2000 (most negative) is sent as 0x0000, 0x0000 is sent as 0x2000, 0x1FFF is sent as 0x3FFF and 0x3FFF (minus one) is sent as 0x1FFF.
- R10: Between the rise of `cs_n_o` that ends one frame and the fall that starts the next, `cs_n_o` stays high for at least one serial clock period (20 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request to send `code_i` |
| code_i | input | 14 | Code to transmit |
| bipolar_i | input | 1 | Treat `code_i` as two's complement for this frame |
| four_wire_i | input | 1 | Issue a load strobe after this frame |
| ready_o | output | 1 | Controller is idle and accepts a request |
| ack_o | output | 1 | One-cycle pulse confirming capture |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data, changed while `sclk_o` is low |
| stb_n_o | output | 1 | Active-low load strobe |

## Verification
The case hardest to reach from the ports is the shortest legal gap between frames. That gap only appears when a new request lands in the very first idle cycle after a frame with no strobe. The driver therefore waits on `ready_o` at each falling clock edge and raises `req_i` immediately, so frames run back to back. The stimulus alternates three-wire and four-wire frames, so both paths into the inter-frame gap are measured. A monitor times every edge of the select, clock, data and strobe lines against the cycle minimums. It compares each captured word with the queued expectation, including the bipolar corner codes.

// File: rtl/dac_link_pkg.sv
`timescale 1ns/1ps
package dac_link_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_CS_SETUP,
        ST_SHIFT,
        ST_CS_HOLD,
        ST_STB_WAIT,
        ST_STB_PULSE,
        ST_DONE
    } link_state_e;

    // whole cycles covering a time in ns
    function automatic int cyc_ceil(int ns, int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_code_fmt.sv
`timescale 1ns/1ps
module dac_code_fmt #(
    parameter int CODE_W = 14,
    parameter int SUB_W  = 2
) (
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    bipolar_i,
    output logic [CODE_W+SUB_W-1:0] word_o
);

    logic [CODE_W-1:0] conv;

    always_comb begin
        conv = code_i;
        if (bipolar_i) begin
            conv[CODE_W-1] = ~code_i[CODE_W-1];
        end
    end

    assign word_o = {conv, {SUB_W{1'b0}}};

endmodule

// File: rtl/dac_interval_timer.sv
`timescale 1ns/1ps
module dac_interval_timer #(
    parameter int W       = 12,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/dac_frame_shifter.sv
`timescale 1ns/1ps
module dac_frame_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         msb_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = word_i;
        end else if (shift_i) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb_o = sr_q[W-1];

    // R3
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (msb_o == $past(word_i[W-1])));

endmodule

// File: rtl/dac_link_ctrl.sv
`timescale 1ns/1ps
module dac_link_ctrl
    import dac_link_pkg::*;
#(
    parameter int CODE_W          = 14,
    parameter int SUB_W           = 2,
    parameter int CLK_PERIOD_NS   = 5,
    parameter int POWERUP_NS      = 20000,
    parameter int SCLK_HALF_NS    = 50,
    parameter int CS_SETUP_NS     = 45,
    parameter int DIN_SETUP_NS    = 40,
    parameter int CS_HOLD_NS      = 45,
    parameter int STB_SETUP_NS    = 50,
    parameter int STB_WIDTH_NS    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              bipolar_i,
    input  logic              four_wire_i,
    output logic              ready_o,
    output logic              ack_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              stb_n_o
);

    localparam int FRAME_W = CODE_W + SUB_W;
    localparam int BW      = $clog2(FRAME_W + 1);
    localparam int T_PWR   = imax(1, cyc_ceil(POWERUP_NS, CLK_PERIOD_NS));
    localparam int T_HALF  = imax(1, cyc_ceil(SCLK_HALF_NS, CLK_PERIOD_NS));
    localparam int T_CSS   = imax(1, imax(cyc_ceil(CS_SETUP_NS, CLK_PERIOD_NS),
                                          cyc_ceil(DIN_SETUP_NS, CLK_PERIOD_NS)));
    localparam int T_CSH   = imax(1, cyc_ceil(CS_HOLD_NS, CLK_PERIOD_NS));
    localparam int T_STS   = imax(1, cyc_ceil(STB_SETUP_NS, CLK_PERIOD_NS));
    localparam int T_STW   = imax(1, cyc_ceil(STB_WIDTH_NS, CLK_PERIOD_NS));
    localparam int T_GAP   = 2 * T_HALF;
    localparam int T_MAX   = imax(imax(T_PWR, T_GAP), imax(imax(T_CSS, T_CSH), imax(T_STS, T_STW)));
    localparam int TW      = $clog2(T_MAX + 1);

    typedef struct packed {
        link_state_e     st;
        logic [BW-1:0]   bits;
        logic            sclk;
        logic            cs_n;
        logic            stb_n;
        logic            ack;
        logic            four;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic              t_zero;
    logic              sh_load;
    logic              sh_shift;
    logic [FRAME_W-1:0] word;

    dac_code_fmt #(
        .CODE_W (CODE_W),
        .SUB_W  (SUB_W)
    ) i_fmt (
        .code_i    (code_i),
        .bipolar_i (bipolar_i),
        .word_o    (word)
    );

    dac_interval_timer #(
        .W       (TW),
        .RST_VAL (T_PWR - 1)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    dac_frame_shifter #(
        .W (FRAME_W)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .word_i  (word),
        .shift_i (sh_shift),
        .msb_o   (sdo_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.ack = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (ctl_q.st)
            ST_POWERUP: begin
                if (t_zero) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (req_i) begin
                    sh_load    = 1'b1;
                    ctl_d.ack  = 1'b1;
                    ctl_d.four = four_wire_i;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.st   = ST_CS_SETUP;
                    t_load     = 1'b1;
                    t_val      = TW'(T_CSS - 1);
                end
            end
            ST_CS_SETUP: begin
                if (t_zero) begin
                    ctl_d.sclk = 1'b1;
                    ctl_d.bits = '0;
                    ctl_d.st   = ST_SHIFT;
                    t_load     = 1'b1;
                    t_val      = TW'(T_HALF - 1);
                end
            end
            ST_SHIFT: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (ctl_q.sclk) begin
                        ctl_d.sclk = 1'b0;
                        if (ctl_q.bits == BW'(FRAME_W - 1)) begin
                            ctl_d.st = ST_CS_HOLD;
                            t_val    = TW'(T_CSH - 1);
                        end else begin
                            sh_shift = 1'b1;
                            t_val    = TW'(T_HALF - 1);
                        end
                    end else begin
                        ctl_d.sclk = 1'b1;
                        ctl_d.bits = ctl_q.bits + 1'b1;
                        t_val      = TW'(T_HALF - 1);
                    end
                end
            end
            ST_CS_HOLD: begin
                if (t_zero) begin
                    ctl_d.cs_n = 1'b1;
                    t_load     = 1'b1;
                    if (ctl_q.four) begin
                        ctl_d.st = ST_STB_WAIT;
                        t_val    = TW'(T_STS - 1);
                    end else begin
                        ctl_d.st = ST_DONE;
                        t_val    = TW'(T_GAP - 1);
                    end
                end
            end
            ST_STB_WAIT: begin
                if (t_zero) begin
                    ctl_d.stb_n = 1'b0;
                    ctl_d.st    = ST_STB_PULSE;
                    t_load      = 1'b1;
                    t_val       = TW'(T_STW - 1);
                end
            end
            ST_STB_PULSE: begin
                if (t_zero) begin
                    ctl_d.stb_n = 1'b1;
                    ctl_d.st    = ST_DONE;
                    t_load      = 1'b1;
                    t_val       = TW'(T_GAP - 1);
                end
            end
            ST_DONE: begin
                if (t_zero) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_POWERUP, bits: '0, sclk: 1'b0, cs_n: 1'b1,
                       stb_n: 1'b1, ack: 1'b0, four: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o = (ctl_q.st == ST_IDLE);
    assign ack_o   = ctl_q.ack;
    assign cs_n_o  = ctl_q.cs_n;
    assign sclk_o  = ctl_q.sclk;
    assign stb_n_o = ctl_q.stb_n;

    // R1
    powerup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_POWERUP) |-> cs_n_o);

    // R2
    ready_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> !ready_o);

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (ctl_q.bits == BW'(FRAME_W - 1)));

    // R4
    sclk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SHIFT && !t_zero) |=> $stable(sclk_o));

    // R5
    sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> !sclk_o);

    // R7
    stb_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n_o |-> cs_n_o);

endmodule

// File: tb/test_dac_link_ctrl.sv
`timescale 1ns/1ps
module test_dac_link_ctrl;

    localparam int T_PWR  = 4000;
    localparam int T_HALF = 10;
    localparam int T_CSS  = 9;
    localparam int T_DS   = 8;
    localparam int T_CSH  = 9;
    localparam int T_LDS  = 10;
    localparam int T_LDW  = 10;
    localparam int T_GAP  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [13:0] code = '0;
    logic        bip = 1'b0;
    logic        four = 1'b0;
    logic        ready, ack, cs_n, sclk, sdo, stb_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] w;
        bit          stb;
        string       tag;
    } exp_t;
    exp_t q_exp[$];

    always #2.5 clk = ~clk;

    dac_link_ctrl i_dac_link_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .code_i      (code),
        .bipolar_i   (bip),
        .four_wire_i (four),
        .ready_o     (ready),
        .ack_o       (ack),
        .cs_n_o      (cs_n),
        .sclk_o      (sclk),
        .sdo_o       (sdo),
        .stb_n_o     (stb_n)
    );

    task automatic chk(bit ok, string req_tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
        end
    endtask

    // monitor state
    bit          mon_en = 1'b0;
    bit          prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0, prev_stb = 1'b1;
    int          cs_run = 0, sclk_run = 0, sdo_run = 0, stb_run = 0;
    int          since_rise = 0, since_csrise = 0;
    int          nbits = 0;
    bit          first_rise = 1'b0;
    logic [15:0] got = '0;
    bit          have_frame = 1'b0, stb_pending = 1'b0, stb_seen = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_cs && !cs_n) begin
                if (have_frame) begin
                    chk(since_csrise >= T_GAP, "R10", "select high gap", since_csrise, T_GAP);
                    chk(stb_seen == stb_pending, stb_pending ? "R7" : "R8",
                        "strobe presence", stb_seen, stb_pending);
                end
                chk(!ready, "R2", "ready during frame", ready, 0);
                nbits = 0;
                got = '0;
                first_rise = 1'b1;
            end
            if (!cs_n && !prev_sclk && sclk) begin
                if (first_rise) begin
                    chk(cs_run >= T_CSS, "R5", "select to first rise", cs_run, T_CSS);
                end else begin
                    chk(sclk_run == T_HALF, "R4", "low phase", sclk_run, T_HALF);
                end
                chk(sdo_run >= T_DS, "R5", "data setup", sdo_run, T_DS);
                got = {got[14:0], sdo};
                nbits++;
                since_rise = 0;
                first_rise = 1'b0;
            end
            if (!cs_n && sclk && (sdo !== prev_sdo)) begin
                chk(1'b0, "R5", "data changed while clock high", sdo, prev_sdo);
            end
            if (prev_sclk && !sclk) begin
                chk(sclk_run == T_HALF, "R4", "high phase", sclk_run, T_HALF);
            end
            if (!prev_cs && cs_n) begin
                chk(nbits == 16, "R3", "rising edges per frame", nbits, 16);
                chk(since_rise >= T_CSH, "R6", "last rise to select high", since_rise, T_CSH);
                if (q_exp.size() == 0) begin
                    chk(1'b0, "R3", "unexpected frame", got, 0);
                    stb_pending = 1'b0;
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    chk(got == e.w, e.tag, "frame word", got, e.w);
                    stb_pending = e.stb;
                end
                stb_seen = 1'b0;
                have_frame = 1'b1;
                since_csrise = 0;
            end
            if (prev_stb && !stb_n) begin
                stb_seen = 1'b1;
                chk(cs_n, "R7", "strobe while selected", cs_n, 1);
                chk(since_csrise >= T_LDS, "R7", "strobe delay", since_csrise, T_LDS);
            end
            if (!prev_stb && stb_n) begin
                chk(stb_run >= T_LDW, "R7", "strobe width", stb_run, T_LDW);
            end
            cs_run   = (cs_n  == prev_cs)   ? cs_run + 1   : 1;
            sclk_run = (sclk  == prev_sclk) ? sclk_run + 1 : 1;
            sdo_run  = (sdo   == prev_sdo)  ? sdo_run + 1  : 1;
            stb_run  = (stb_n == prev_stb)  ? stb_run + 1  : 1;
            since_rise++;
            since_csrise++;
            prev_cs = cs_n; prev_sclk = sclk; prev_sdo = sdo; prev_stb = stb_n;
        end
    end

    task automatic send(logic [13:0] c, bit b, bit fw, logic [13:0] exp_code, string tag);
        exp_t e;
        while (!ready) @(negedge clk);
        code = c;
        bip = b;
        four = fw;
        req = 1'b1;
        e.w = {exp_code, 2'b00};
        e.stb = fw;
        e.tag = tag;
        q_exp.push_back(e);
        @(negedge clk);
        req = 1'b0;
        chk(ack == 1'b1, "R2", "ack after capture", ack, 1);
        chk(ready == 1'b0, "R2", "ready after capture", ready, 0);
        @(negedge clk);
        chk(ack == 1'b0, "R2", "ack single cycle", ack, 0);
    endtask

    initial begin
        int low_cnt;
        bit cs_ok;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && stb_n == 1'b1, "R1", "reset outputs",
            {cs_n, sclk, stb_n}, 3'b101);
        chk(ready == 1'b0 && ack == 1'b0, "R1", "reset handshake", {ready, ack}, 0);
        rst_n = 1'b1;
        low_cnt = 0;
        cs_ok = 1'b1;
        while (!ready && low_cnt < T_PWR + 10) begin
            @(negedge clk);
            if (!cs_n) cs_ok = 1'b0;
            if (!ready) low_cnt++;
        end
        chk(low_cnt >= T_PWR - 1 && low_cnt <= T_PWR + 2, "R1", "power-up wait", low_cnt, T_PWR);
        chk(cs_ok, "R1", "select high in power-up", cs_ok, 1);
        mon_en = 1'b1;
        // R3 / R9 unsigned three-wire, back to back
        send(14'h3FFF, 1'b0, 1'b0, 14'h3FFF, "R3");
        send(14'h0000, 1'b0, 1'b0, 14'h0000, "R3");
        send(14'h2AAA, 1'b0, 1'b0, 14'h2AAA, "R9");
        // R7 four-wire
        send(14'h1234, 1'b0, 1'b1, 14'h1234, "R7");
        send(14'h0001, 1'b0, 1'b0, 14'h0001, "R8");
        // R9 bipolar corners
        send(14'h2000, 1'b1, 1'b0, 14'h0000, "R9");
        send(14'h0000, 1'b1, 1'b1, 14'h2000, "R9");
        send(14'h1FFF, 1'b1, 1'b0, 14'h3FFF, "R9");
        send(14'h3FFF, 1'b1, 1'b1, 14'h1FFF, "R9");
        while (!ready || q_exp.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(stb_seen == stb_pending, "R7", "last frame strobe", stb_seen, stb_pending);
        chk(q_exp.size() == 0, "R3", "frames outstanding", q_exp.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule